// File: doc/BRIEF.md
# Relative Countdown Alarm with Interrupt

This block is a wake-up alarm that counts down a relative interval, not one that compares against an absolute date. Software writes an interval into one packed countdown register. The interval has separate day, hour, minute and second fields. Software then enables the counter. Each one-second tick pulse takes one second off the interval. A borrow ripples upward through the fields: seconds, then minutes, then hours, then days.

When the interval runs out, a pending flag is latched and the counter stays at zero. Software clears the flag by writing a 1 to it. An interrupt line is raised whenever the flag is pending and the interrupt enable is set.

Access is through a simple synchronous register port. A write takes effect at the clock edge on which it is presented. A read returns its data on the cycle after the request. A read of the countdown register returns the live remaining interval.

Top module: `rel_alarm`

## Requirements
- R1: After reset, the countdown, counter enable, interrupt enable and pending flag read as zero, and `irq_o` is low.
- R2: A write to offset 0x0C loads the countdown register, and a read of that offset returns the live count. The field layout is seconds in bits [5:0], minutes in [13:8], hours in [20:16] and days in [28:21].
- R3: On a tick, while the counter is enabled and the count is nonzero, the count drops by exactly one second. Without a tick, or while the counter is disabled, the count does not change.
- R4: The decrement borrows field by field. Seconds at 0 become 59 and minutes drop by one. Minutes at 0 become 59 and hours drop by one. Hours at 0 become 23 and days drop by one.
- R5: When an enabled tick takes the count from one second to zero, the pending flag sets. The count then stays at zero. Further ticks at zero never set the flag again.
- R6: Writing a value with bit 0 set to offset 0x1C clears the pending flag. Writing bit 0 as 0 leaves the flag unchanged. The flag reads back at bit 0 of that offset.
- R7: `irq_o` is high exactly when the pending flag is set and the interrupt enable is set.
- R8: If the flag sets on the same cycle as a write-1-to-clear, the flag ends up set.
- R9: Writing zero to the countdown register discards any remaining count, and no pending flag results from it.
- R10: The counter enable is bit 8 of offset 0x14 and the interrupt enable is bit 0 of offset 0x18. Both read back at those positions. The day field holds values up to 255.
- R11: A countdown write on the same cycle as an enabled tick loads the written value, not a decremented one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the cycle after `rd_en_i` |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The bench builds the block with its defaults: an 8-bit day field, 32-bit data and 8-bit offsets. With these values, the largest day count of 255 and each borrow boundary can be reached by loading intervals that sit one tick from the edge. This avoids counting out a full day. Collisions are forced by presenting a tick in the same cycle as a clear or a load. These collisions cover the set-versus-clear rule and the load-versus-decrement rule.

// File: rtl/rel_alarm_pkg.sv
package rel_alarm_pkg;
  // register offsets
  localparam logic [7:0] OFS_COUNT = 8'h0C;
  localparam logic [7:0] OFS_RUN   = 8'h14;
  localparam logic [7:0] OFS_IEN   = 8'h18;
  localparam logic [7:0] OFS_STAT  = 8'h1C;
  // bit positions inside the registers
  localparam int SEC_LSB  = 0;
  localparam int MIN_LSB  = 8;
  localparam int HR_LSB   = 16;
  localparam int DAY_LSB  = 21;
  localparam int RUN_BIT  = 8;
  localparam int IEN_BIT  = 0;
  localparam int PEND_BIT = 0;
  // field moduli
  localparam int SEC_MOD = 60;
  localparam int MIN_MOD = 60;
  localparam int HR_MOD  = 24;
endpackage

// File: rtl/rel_alarm_count.sv
module rel_alarm_count #(
  parameter int DAY_W   = 8,
  parameter int SEC_MOD = 60,
  parameter int MIN_MOD = 60,
  parameter int HR_MOD  = 24,
  localparam int SEC_W  = $clog2(SEC_MOD),
  localparam int MIN_W  = $clog2(MIN_MOD),
  localparam int HR_W   = $clog2(HR_MOD)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [SEC_W-1:0] ld_sec_i,
  input  logic [MIN_W-1:0] ld_min_i,
  input  logic [HR_W-1:0]  ld_hr_i,
  input  logic [DAY_W-1:0] ld_day_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [MIN_W-1:0] min_o,
  output logic [HR_W-1:0]  hr_o,
  output logic [DAY_W-1:0] day_o,
  output logic             hit_o
);
  logic [SEC_W-1:0] sec_q, sec_n;
  logic [MIN_W-1:0] min_q, min_n;
  logic [HR_W-1:0]  hr_q,  hr_n;
  logic [DAY_W-1:0] day_q, day_n;
  logic is_zero, at_one, dec_en;
  logic borrow_min, borrow_hr, borrow_day;

  assign is_zero = (sec_q == '0) && (min_q == '0) && (hr_q == '0) && (day_q == '0);
  assign at_one  = (sec_q == SEC_W'(1)) && (min_q == '0) && (hr_q == '0) && (day_q == '0);
  assign dec_en  = tick_i && run_i && !is_zero;

  // borrow chain: each field wraps to its top value when it underflows
  always_comb begin
    borrow_min = (sec_q == '0);
    borrow_hr  = borrow_min && (min_q == '0);
    borrow_day = borrow_hr && (hr_q == '0);
    sec_n = (sec_q == '0) ? SEC_W'(SEC_MOD - 1) : sec_q - SEC_W'(1);
    min_n = min_q;
    hr_n  = hr_q;
    day_n = day_q;
    if (borrow_min) min_n = (min_q == '0) ? MIN_W'(MIN_MOD - 1) : min_q - MIN_W'(1);
    if (borrow_hr)  hr_n  = (hr_q == '0) ? HR_W'(HR_MOD - 1) : hr_q - HR_W'(1);
    if (borrow_day) day_n = day_q - DAY_W'(1);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sec_q <= '0; min_q <= '0; hr_q <= '0; day_q <= '0;
    end else if (load_i) begin
      sec_q <= ld_sec_i; min_q <= ld_min_i; hr_q <= ld_hr_i; day_q <= ld_day_i;
    end else if (dec_en) begin
      sec_q <= sec_n; min_q <= min_n; hr_q <= hr_n; day_q <= day_n;
    end
  end

  assign hit_o = dec_en && at_one && !load_i;
  assign sec_o = sec_q;
  assign min_o = min_q;
  assign hr_o  = hr_q;
  assign day_o = day_q;

  // R3: count holds without an enabled tick
  p_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && !(tick_i && run_i)) |=> $stable({day_q, hr_q, min_q, sec_q}));
  // R3: nonzero seconds drop by one
  p_dec_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && tick_i && run_i && sec_q != '0) |=> sec_q == $past(sec_q) - SEC_W'(1));
  // R4: seconds wrap on borrow
  p_borrow_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && tick_i && run_i && sec_q == '0 && !is_zero) |=> sec_q == SEC_W'(SEC_MOD - 1));
  // R5: counter parks at zero
  p_stop_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && is_zero) |=> (sec_q == '0 && min_q == '0 && hr_q == '0 && day_q == '0));
  // R11: a load wins over a decrement
  p_load_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> (sec_q == $past(ld_sec_i) && day_q == $past(ld_day_i)));
endmodule

// File: rtl/rel_alarm_irq.sv
module rel_alarm_irq (
  input  logic clk_i,
  input  logic rst_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic ien_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)      pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q & ien_i;

  // R8: a set beats a clear in the same cycle
  p_set_r8: assert property (@(posedge clk_i) disable iff (rst_i) set_i |=> pend_q);
  // R6: a clear alone drops the flag
  p_clr_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_i && !set_i) |=> !pend_q);
  // R5: flag holds when neither event occurs
  p_keep_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (!set_i && !clr_i) |=> $stable(pend_q));
endmodule

// File: rtl/rel_alarm_regs.sv
module rel_alarm_regs
  import rel_alarm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int DAY_W  = 8,
  parameter int SEC_W  = 6,
  parameter int MIN_W  = 6,
  parameter int HR_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [MIN_W-1:0]  min_i,
  input  logic [HR_W-1:0]   hr_i,
  input  logic [DAY_W-1:0]  day_i,
  input  logic              pend_i,
  output logic              load_o,
  output logic [SEC_W-1:0]  ld_sec_o,
  output logic [MIN_W-1:0]  ld_min_o,
  output logic [HR_W-1:0]   ld_hr_o,
  output logic [DAY_W-1:0]  ld_day_o,
  output logic              clr_o,
  output logic              run_o,
  output logic              ien_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic sel_cnt, sel_run, sel_ien, sel_stat;
  logic run_q, ien_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic unused_wdata;

  assign sel_cnt  = (addr_i == ADDR_W'(OFS_COUNT));
  assign sel_run  = (addr_i == ADDR_W'(OFS_RUN));
  assign sel_ien  = (addr_i == ADDR_W'(OFS_IEN));
  assign sel_stat = (addr_i == ADDR_W'(OFS_STAT));

  assign load_o   = wr_en_i && sel_cnt;
  assign ld_sec_o = wdata_i[SEC_LSB +: SEC_W];
  assign ld_min_o = wdata_i[MIN_LSB +: MIN_W];
  assign ld_hr_o  = wdata_i[HR_LSB  +: HR_W];
  assign ld_day_o = wdata_i[DAY_LSB +: DAY_W];
  assign clr_o    = wr_en_i && sel_stat && wdata_i[PEND_BIT];
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q <= 1'b0;
      ien_q <= 1'b0;
    end else if (wr_en_i) begin
      if (sel_run) run_q <= wdata_i[RUN_BIT];
      if (sel_ien) ien_q <= wdata_i[IEN_BIT];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_cnt) begin
      rd_mux[SEC_LSB +: SEC_W] = sec_i;
      rd_mux[MIN_LSB +: MIN_W] = min_i;
      rd_mux[HR_LSB  +: HR_W]  = hr_i;
      rd_mux[DAY_LSB +: DAY_W] = day_i;
    end
    if (sel_run)  rd_mux[RUN_BIT]  = run_q;
    if (sel_ien)  rd_mux[IEN_BIT]  = ien_q;
    if (sel_stat) rd_mux[PEND_BIT] = pend_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign run_o   = run_q;
  assign ien_o   = ien_q;
  assign rdata_o = rdata_q;

  // R10: enable registers follow their write bits
  p_run_wr_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && sel_run) |=> run_q == $past(wdata_i[RUN_BIT]));
  // R1: read data only moves on a read strobe
  p_rd_hold_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_en_i |=> $stable(rdata_q));
endmodule

// File: rtl/rel_alarm.sv
module rel_alarm
  import rel_alarm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int DAY_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int SEC_W = $clog2(SEC_MOD);
  localparam int MIN_W = $clog2(MIN_MOD);
  localparam int HR_W  = $clog2(HR_MOD);

  logic             load, clr, run, ien, hit, pend;
  logic [SEC_W-1:0] ld_sec, sec;
  logic [MIN_W-1:0] ld_min, min;
  logic [HR_W-1:0]  ld_hr, hr;
  logic [DAY_W-1:0] ld_day, day;

  rel_alarm_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DAY_W(DAY_W),
    .SEC_W(SEC_W), .MIN_W(MIN_W), .HR_W(HR_W)
  ) regs_i (
    .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i),
    .sec_i(sec), .min_i(min), .hr_i(hr), .day_i(day), .pend_i(pend),
    .load_o(load), .ld_sec_o(ld_sec), .ld_min_o(ld_min), .ld_hr_o(ld_hr),
    .ld_day_o(ld_day), .clr_o(clr), .run_o(run), .ien_o(ien), .rdata_o(rdata_o)
  );

  rel_alarm_count #(
    .DAY_W(DAY_W), .SEC_MOD(SEC_MOD), .MIN_MOD(MIN_MOD), .HR_MOD(HR_MOD)
  ) count_i (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i), .run_i(run), .load_i(load),
    .ld_sec_i(ld_sec), .ld_min_i(ld_min), .ld_hr_i(ld_hr), .ld_day_i(ld_day),
    .sec_o(sec), .min_o(min), .hr_o(hr), .day_o(day), .hit_o(hit)
  );

  rel_alarm_irq irq_i (
    .clk_i(clk_i), .rst_i(rst_i), .set_i(hit), .clr_i(clr), .ien_i(ien),
    .pend_o(pend), .irq_o(irq_o)
  );

  // R7: interrupt only with both flag and enable
  p_irq_gate_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> (pend && ien));
endmodule

// File: tb/rel_alarm_tb_top.sv
module rel_alarm_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rel_alarm dut_i (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] pk(int d, int h, int m, int s);
    return (32'(d) << 21) | (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h0C, v); chk("R1 count", v, 0);
    rd(8'h14, v); chk("R1 run", v, 0);
    rd(8'h18, v); chk("R1 ien", v, 0);
    rd(8'h1C, v); chk("R1 pend", v, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    wr(8'h0C, pk(200, 13, 45, 30)); rd(8'h0C, v); chk("R2 layout", v, pk(200, 13, 45, 30));
    wr(8'h0C, pk(255, 0, 0, 1));    rd(8'h0C, v); chk("R10 day 255", v, pk(255, 0, 0, 1));
    wr(8'h14, 32'h100); rd(8'h14, v); chk("R10 run bit8", v, 32'h100);
    wr(8'h18, 32'h1);   rd(8'h18, v); chk("R10 ien bit0", v, 32'h1);
    wr(8'h14, 32'h0);   wr(8'h18, 32'h0);
  endtask

  task automatic t_decrement();
    logic [31:0] v;
    wr(8'h0C, pk(0, 2, 10, 30));
    ticks(3); rd(8'h0C, v); chk("R3 disabled hold", v, pk(0, 2, 10, 30));
    wr(8'h14, 32'h100);
    repeat (4) @(negedge clk);
    rd(8'h0C, v); chk("R3 no tick hold", v, pk(0, 2, 10, 30));
    ticks(3); rd(8'h0C, v); chk("R3 three ticks", v, pk(0, 2, 10, 27));
  endtask

  task automatic t_borrow();
    logic [31:0] v;
    wr(8'h0C, pk(1, 0, 0, 0)); ticks(1); rd(8'h0C, v); chk("R4 day borrow", v, pk(0, 23, 59, 59));
    wr(8'h0C, pk(0, 1, 0, 0)); ticks(1); rd(8'h0C, v); chk("R4 hour borrow", v, pk(0, 0, 59, 59));
    wr(8'h0C, pk(0, 0, 1, 0)); ticks(1); rd(8'h0C, v); chk("R4 min borrow", v, pk(0, 0, 0, 59));
    wr(8'h0C, pk(255, 0, 0, 0)); ticks(1); rd(8'h0C, v); chk("R4 top day", v, pk(254, 23, 59, 59));
  endtask

  task automatic t_expire();
    logic [31:0] v;
    wr(8'h18, 32'h1);
    wr(8'h0C, pk(0, 0, 0, 2));
    ticks(1); rd(8'h1C, v); chk("R5 not yet", v, 0); chk("R7 irq low", 32'(irq), 0);
    ticks(1); rd(8'h1C, v); chk("R5 pending", v, 1); chk("R7 irq high", 32'(irq), 1);
    ticks(2); rd(8'h0C, v); chk("R5 parked at zero", v, 0);
    wr(8'h1C, 32'h0); rd(8'h1C, v); chk("R6 write 0 keeps", v, 1);
    wr(8'h18, 32'h0); chk("R7 masked", 32'(irq), 0);
    wr(8'h18, 32'h1); chk("R7 unmasked", 32'(irq), 1);
    wr(8'h1C, 32'h1); rd(8'h1C, v); chk("R6 w1c", v, 0); chk("R7 irq drops", 32'(irq), 0);
    ticks(3); rd(8'h1C, v); chk("R5 sets once", v, 0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(8'h0C, pk(0, 0, 0, 1));
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 8'h1C; wdata = 32'h1;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(8'h1C, v); chk("R8 set wins", v, 1);
    wr(8'h1C, 32'h1);
  endtask

  task automatic t_zero_write();
    logic [31:0] v;
    wr(8'h0C, pk(0, 0, 0, 5)); ticks(1);
    wr(8'h0C, 32'h0); rd(8'h0C, v); chk("R9 cleared", v, 0);
    ticks(2); rd(8'h1C, v); chk("R9 no pending", v, 0);
  endtask

  task automatic t_load_tick();
    logic [31:0] v;
    wr(8'h0C, pk(0, 0, 0, 9));
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 8'h0C; wdata = pk(0, 0, 0, 40);
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(8'h0C, v); chk("R11 load wins", v, pk(0, 0, 0, 40));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fields();
    t_decrement();
    t_borrow();
    t_expire();
    t_collide();
    t_zero_write();
    t_load_tick();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule